// File: doc/BRIEF.md
# In-Order Shared-Slave Bus Arbiter

This block lets several pipelined bus masters share one slave port, typically a memory controller with long read latency, without any master holding the slave for the length of its transaction. Each cycle a round-robin choice picks one requesting master, and its request is forwarded to the slave. Requests from different masters can therefore interleave one beat at a time, and many can be in flight together.

The slave must answer in the order it accepted requests. Each time the slave accepts a request, the index of the master that issued it is pushed into a small ID queue. Each acknowledgement goes to the master at the head of that queue, and the queue is then popped. Read data from the slave is broadcast to all masters, and the acknowledge line marks the master that owns it.

A bus error from the slave cannot be attributed to one request. It is therefore reported to every master whose cycle line is high, and all outstanding bookkeeping is dropped. The block does not support locked or atomic multi-request sequences.

Top module: `inorder_arb`

## Requirements
- R1: While reset is held and right after it is released with no requests, `s_stb`, `m_ack` and `m_err` are all low, every bit of `m_stall` is high, and the round-robin pointer starts at master 0.
- R2: Among masters with both `m_cyc` and `m_stb` high, the grant goes to the first one found by searching upward (with wraparound) from the index one above the last accepted master.
- R3: `s_stb` is high only when some master requests, fewer than DEPTH requests are outstanding and `s_err` is low. While it is high, `s_we` and `s_wdat` equal the granted master's fields.
- R4: `m_stall[i]` is low only when master i is granted, `s_stb` is high and `s_stall` is low. At most one master sees its stall low in a cycle.
- R5: Each accepted request records its master index. When `s_ack` is high, `s_err` is low and a request is outstanding, exactly the oldest outstanding request's master gets `m_ack`. `m_rdat` always equals `s_rdat`.
- R6: An `s_ack` that arrives with no request outstanding produces no `m_ack`.
- R7: When DEPTH requests are outstanding, `s_stb` stays low and all masters stay stalled, even if an acknowledgement arrives in that same cycle.
- R8: When `s_err` is high, `m_err[i]` equals `m_cyc[i]` for every master, no request is accepted, and no `m_ack` is given.
- R9: After a cycle with `s_err`, no requests are outstanding. Acknowledgements are ignored until new requests are accepted.
- R10: `s_cyc` is the OR of all `m_cyc` lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_cyc | input | N | Per-master bus cycle active |
| m_stb | input | N | Per-master request strobe |
| m_we | input | N | Per-master write enable |
| m_adr | input | N*AW | Packed per-master addresses, master i at bits [i*AW +: AW] |
| m_wdat | input | N*DW | Packed per-master write data, master i at bits [i*DW +: DW] |
| m_stall | output | N | Per-master stall; low means the request is taken this cycle |
| m_ack | output | N | Per-master acknowledge |
| m_err | output | N | Per-master bus error |
| m_rdat | output | DW | Read data broadcast to all masters |
| s_cyc | output | 1 | Slave bus cycle active |
| s_stb | output | 1 | Slave request strobe |
| s_we | output | 1 | Slave write enable |
| s_adr | output | AW | Slave address |
| s_wdat | output | DW | Slave write data |
| s_stall | input | 1 | Slave stall |
| s_ack | input | 1 | Slave acknowledge, in request order |
| s_err | input | 1 | Slave bus error |
| s_rdat | input | DW | Slave read data |

## Verification
The assertions watch, on every cycle, the properties that need no knowledge of the order of requests:
- at most one acknowledge and at most one released stall;
- no strobe without a requester;
- no strobe with the ID queue full or during an error;
- error lines that follow the active cycle lines;
- silence on the acknowledge lines right after an error;
- no acknowledge without an outstanding request, tracked by the checker's own count.

Whether each acknowledge reaches the right master, and whether the round-robin order is fair, depends on the history of accepted requests. Only the bench's reference model can show this, by keeping the queue of accepted indices and the rotating pointer. The bench also drives the full-queue, ack-with-nothing-pending and error-then-stray-ack cases.

// File: rtl/inorder_arb_pkg.sv
package inorder_arb_pkg;
    // Index reached by stepping off places upward from base, wrapping at n.
    function automatic int unsigned rr_offset(input int unsigned base,
                                              input int unsigned off,
                                              input int unsigned n);
        return (base + off) % n;
    endfunction
endpackage

// File: rtl/inorder_arb_rr.sv
module inorder_arb_rr
    import inorder_arb_pkg::*;
#(
    parameter int N  = 4,
    parameter int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic          gnt_vld,
    output logic [IW-1:0] gnt_idx
);
    typedef struct packed {
        logic [IW-1:0] ptr;
    } rr_state_t;

    rr_state_t     st_d, st_q;
    logic [IW-1:0] cand;

    always_comb begin
        st_d    = st_q;
        gnt_vld = 1'b0;
        gnt_idx = '0;
        cand    = '0;
        // Scan from farthest to nearest so the nearest requester wins.
        for (int k = N - 1; k >= 0; k--) begin
            cand = IW'(rr_offset(int'(st_q.ptr), k, N));
            if (req[cand]) begin
                gnt_vld = 1'b1;
                gnt_idx = cand;
            end
        end
        if (adv && gnt_vld) begin
            st_d.ptr = IW'(rr_offset(int'(gnt_idx), 1, N));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/inorder_arb_idq.sv
module inorder_arb_idq #(
    parameter int DEPTH = 8,
    parameter int IW    = 2,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [IW-1:0] din,
    input  logic          pop,
    input  logic          flush,
    output logic [IW-1:0] head,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [DEPTH-1:0][IW-1:0] mem;
        logic [PW-1:0]            wp;
        logic [PW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } idq_state_t;

    idq_state_t st_d, st_q;
    logic       push_ok, pop_ok;

    always_comb begin
        st_d    = st_q;
        full    = (st_q.cnt == CW'(DEPTH));
        empty   = (st_q.cnt == '0);
        head    = st_q.mem[st_q.rp];
        push_ok = push && !full;
        pop_ok  = pop && !empty;
        if (flush) begin
            st_d.wp  = '0;
            st_d.rp  = '0;
            st_d.cnt = '0;
        end else begin
            if (push_ok) begin
                st_d.mem[st_q.wp] = din;
                st_d.wp           = st_q.wp + PW'(1);
            end
            if (pop_ok) begin
                st_d.rp = st_q.rp + PW'(1);
            end
            st_d.cnt = st_q.cnt + CW'(push_ok) - CW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/inorder_arb.sv
module inorder_arb #(
    parameter int N     = 4,
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    m_cyc,
    input  logic [N-1:0]    m_stb,
    input  logic [N-1:0]    m_we,
    input  logic [N*AW-1:0] m_adr,
    input  logic [N*DW-1:0] m_wdat,
    output logic [N-1:0]    m_stall,
    output logic [N-1:0]    m_ack,
    output logic [N-1:0]    m_err,
    output logic [DW-1:0]   m_rdat,
    output logic            s_cyc,
    output logic            s_stb,
    output logic            s_we,
    output logic [AW-1:0]   s_adr,
    output logic [DW-1:0]   s_wdat,
    input  logic            s_stall,
    input  logic            s_ack,
    input  logic            s_err,
    input  logic [DW-1:0]   s_rdat
);
    logic [N-1:0]  req;
    logic          gnt_vld, fire, q_full, q_empty, q_pop;
    logic [IW-1:0] gnt_idx, q_head;

    assign req = m_cyc & m_stb;

    inorder_arb_rr #(.N(N), .IW(IW)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req),
        .adv     (fire),
        .gnt_vld (gnt_vld),
        .gnt_idx (gnt_idx)
    );

    inorder_arb_idq #(.DEPTH(DEPTH), .IW(IW)) u_idq (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (fire),
        .din   (gnt_idx),
        .pop   (q_pop),
        .flush (s_err),
        .head  (q_head),
        .full  (q_full),
        .empty (q_empty)
    );

    always_comb begin
        s_stb  = gnt_vld && !q_full && !s_err;
        fire   = s_stb && !s_stall;
        q_pop  = s_ack && !s_err && !q_empty;
        s_cyc  = |m_cyc;
        m_rdat = s_rdat;
        s_we   = 1'b0;
        s_adr  = '0;
        s_wdat = '0;
        for (int i = 0; i < N; i++) begin
            if (gnt_idx == IW'(i)) begin
                s_we   = m_we[i];
                s_adr  = m_adr[i*AW +: AW];
                s_wdat = m_wdat[i*DW +: DW];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_port
        assign m_stall[g] = !(fire && gnt_idx == IW'(g));
        assign m_ack[g]   = q_pop && q_head == IW'(g);
        assign m_err[g]   = s_err && m_cyc[g];
    end
endmodule

// File: rtl/inorder_arb_chk.sv
module inorder_arb_chk #(
    parameter int N     = 4,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] m_cyc,
    input logic [N-1:0] m_stb,
    input logic [N-1:0] m_stall,
    input logic [N-1:0] m_ack,
    input logic [N-1:0] m_err,
    input logic         s_stb,
    input logic         s_stall,
    input logic         s_ack,
    input logic         s_err
);
    logic [CW-1:0] pend_q;
    logic          took;

    assign took = s_stb && !s_stall;

    always_ff @(posedge clk) begin
        if (!rst_n || s_err) pend_q <= '0;
        else pend_q <= pend_q + CW'(took) - CW'(s_ack && pend_q != '0);
    end

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(m_ack)); // R5
    AST_ACK_NEEDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> (m_ack == '0)); // R6
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == CW'(DEPTH)) |-> (!s_stb && m_stall == '1)); // R7
    AST_ERR_TO_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        s_err |-> (m_err == m_cyc && !s_stb && m_ack == '0)); // R8
    AST_FLUSH_AFTER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        s_err |=> (m_ack == '0)); // R9
    AST_ONE_GO: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~m_stall) <= 1); // R4
    AST_GO_IS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((~m_stall & ~(m_cyc & m_stb)) == '0)); // R4
    AST_NO_IDLE_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_cyc & m_stb) == '0) |-> !s_stb); // R3
endmodule

bind inorder_arb inorder_arb_chk #(.N(N), .DEPTH(DEPTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .m_cyc   (m_cyc),
    .m_stb   (m_stb),
    .m_stall (m_stall),
    .m_ack   (m_ack),
    .m_err   (m_err),
    .s_stb   (s_stb),
    .s_stall (s_stall),
    .s_ack   (s_ack),
    .s_err   (s_err)
);

// File: tb/sim_inorder_arb.sv
module sim_inorder_arb;
    localparam int N = 4, AW = 16, DW = 32, DEPTH = 8;

    logic            clk = 1'b0, rst_n = 1'b0;
    logic [N-1:0]    m_cyc = '0, m_stb = '0, m_we = '0;
    logic [N*AW-1:0] m_adr = '0;
    logic [N*DW-1:0] m_wdat = '0;
    logic [N-1:0]    m_stall, m_ack, m_err;
    logic [DW-1:0]   m_rdat, s_wdat;
    logic            s_cyc, s_stb, s_we;
    logic [AW-1:0]   s_adr;
    logic            s_stall = 1'b0, s_ack = 1'b0, s_err = 1'b0;
    logic [DW-1:0]   s_rdat = '0;

    int nchk = 0, nerr = 0;
    int ptr = 0;
    int idq[$];
    int mode = 0;
    bit done = 0;

    always #10 clk = ~clk;

    inorder_arb #(.N(N), .AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (.*);

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic drive(input int cyc_no);
        for (int i = 0; i < N; i++) begin
            m_adr[i*AW +: AW]  = AW'((i << 12) | (cyc_no & 12'hfff));
            m_wdat[i*DW +: DW] = $urandom;
            m_we[i]            = $urandom_range(0, 1);
        end
        s_rdat = $urandom;
        case (mode)
            1: begin // queue fill: everyone asks, slave never answers
                m_stb = '1; m_cyc = '1; s_stall = 0; s_ack = 0; s_err = 0;
            end
            2: begin // drain with a late ack on an empty queue
                m_stb = '0; m_cyc = '1; s_stall = 0; s_ack = 1; s_err = 0;
            end
            3: begin // error-heavy traffic
                m_stb = N'($urandom); m_cyc = m_stb | N'($urandom);
                s_stall = ($urandom_range(0, 3) == 0);
                s_ack = $urandom_range(0, 1); s_err = ($urandom_range(0, 7) == 0);
            end
            default: begin
                m_stb = N'($urandom); m_cyc = m_stb | N'($urandom);
                s_stall = ($urandom_range(0, 3) == 0);
                s_ack = ($urandom_range(0, 2) != 0); s_err = ($urandom_range(0, 99) == 0);
            end
        endcase
    endtask

    // Compare against the reference, then advance it as the next edge will.
    task automatic compare_step();
        logic [N-1:0] req, exp_stall, exp_ack, exp_err;
        int g;
        bit fire;
        req = m_cyc & m_stb;
        g = -1;
        if (!s_err && idq.size() < DEPTH) begin
            for (int k = 0; k < N; k++) begin
                if (g < 0 && req[(ptr + k) % N]) g = (ptr + k) % N;
            end
        end
        fire = (g >= 0) && !s_stall;
        exp_stall = '1;
        if (fire) exp_stall[g] = 1'b0;
        exp_ack = '0;
        if (s_ack && !s_err && idq.size() > 0) exp_ack[idq[0]] = 1'b1;
        exp_err = s_err ? m_cyc : '0;

        check(s_cyc == |m_cyc, "R10", "s_cyc", s_cyc, |m_cyc);
        check(s_stb == (g >= 0), "R3", "s_stb", s_stb, g >= 0);
        if (g >= 0) begin
            check(s_adr == m_adr[g*AW +: AW], "R2", "granted address", s_adr, m_adr[g*AW +: AW]);
            check(s_we == m_we[g] && s_wdat == m_wdat[g*DW +: DW], "R3", "forwarded we/data",
                  {s_we, s_wdat}, {m_we[g], m_wdat[g*DW +: DW]});
        end
        check(m_stall == exp_stall, "R4", "m_stall", m_stall, exp_stall);
        if (s_ack && !s_err && idq.size() == 0)
            check(m_ack == '0, "R6", "ack with nothing pending", m_ack, 0);
        else
            check(m_ack == exp_ack, "R5", "m_ack routing", m_ack, exp_ack);
        check(m_rdat == s_rdat, "R5", "m_rdat", m_rdat, s_rdat);
        if (idq.size() == DEPTH)
            check(!s_stb && m_stall == '1, "R7", "full queue blocks", {s_stb, m_stall}, {1'b0, {N{1'b1}}});
        check(m_err == exp_err, "R8", "m_err", m_err, exp_err);
        if (s_err) check(!s_stb, "R8", "no accept on error", s_stb, 0);

        if (s_err) idq.delete();
        else begin
            if (exp_ack != '0) void'(idq.pop_front());
            if (fire) begin
                idq.push_back(g);
                ptr = (g + 1) % N;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(s_stb == 0 && m_ack == 0 && m_err == 0 && m_stall == '1, "R1", "in reset",
              {s_stb, m_ack, m_err, m_stall}, {1'b0, {N{1'b0}}, {N{1'b0}}, {N{1'b1}}});
        rst_n = 1'b1;
        @(negedge clk);
        check(s_stb == 0 && m_ack == 0 && m_err == 0 && m_stall == '1, "R1", "after reset",
              {s_stb, m_ack, m_err, m_stall}, {1'b0, {N{1'b0}}, {N{1'b0}}, {N{1'b1}}});
        // R1: pointer starts at master 0, so with masters 1 and 3 asking, 1 wins.
        m_cyc = 4'b1010; m_stb = 4'b1010;
        for (int i = 0; i < N; i++) m_adr[i*AW +: AW] = AW'(i);
        #2;
        check(s_adr == AW'(1), "R1", "first grant from index 0", s_adr, 1);
        compare_step();
        for (int c = 0; c < 3000; c++) begin
            @(negedge clk);
            if (c < 1200) mode = 0;
            else if (c < 1220) mode = 1;   // R7: fill the ID queue
            else if (c < 1240) mode = 2;   // R6: acks past empty
            else if (c < 1260) mode = 1;
            else if (c < 1262) mode = 3;
            else if (c < 2000) mode = 3;   // R8, R9: frequent errors
            else mode = 0;
            if (c == 1261) begin           // R9: error then stray ack
                drive(c); s_err = 1; s_ack = 0; #2; compare_step();
                @(negedge clk); drive(c); m_stb = '0; s_err = 0; s_ack = 1;
                #2;
                check(m_ack == '0, "R9", "ack after flush", m_ack, 0);
                compare_step();
            end else begin
                drive(c);
                #2;
                compare_step();
            end
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule